// File: doc/BRIEF.md
# Sector Protection Command Controller

This block sits behind a serial-flash byte deserializer and watches the command bytes of each chip-select frame. It recognises fixed four-byte opcode sequences for chip erase, page-size selection, protection-register erase and program, protection enable and disable, and sector lockdown. It also serves reads of the protection register and of the lockdown state. The protection register and the lockdown bits are nonvolatile in a real part; here they are plain registers.

From the software protection flag, the write-protect pin, the per-sector protection bytes and the lockdown bits it derives a per-sector write-inhibit vector and the protection bit of the status register. Actions that come from a frame take effect when the frame closes. Each such action either produces a one-cycle strobe for the erase and program engines or updates the internal state.

Top module: `sprot_cmd_ctrl`

## Requirements
- R1: The bytes C7h 94h 80h 9Ah as the first four bytes of a frame produce one `chip_erase_stb` pulse in the cycle after chip select falls. Any bytes after the fourth are ignored.
- R2: The first four bytes 3Dh 2Ah 80h A6h produce one `page_bin_stb` pulse in the cycle after the frame ends.
- R3: A frame that ends before its fourth byte, or whose first four bytes match no known sequence, produces no strobe and changes no state.
- R4: The bytes 3Dh 2Ah 7Fh CFh, sent while `wp_n` is high, set every protection-register byte to FFh, pulse `preg_erase_stb` and arm one program.
- R5: The bytes 3Dh 2Ah 7Fh FCh, followed by data bytes (sector 0 first), load the protection register when the frame ends, but only if a program is armed and `wp_n` is high. The load consumes the arm and pulses `preg_prog_stb`. Sectors that receive no data byte get 00h. An unarmed program changes nothing and gives no strobe.
- R6: The bytes 3Dh 2Ah 7Fh A9h switch software protection on, and 3Dh 2Ah 7Fh 9Ah switch it off.
- R7: While `wp_n` is low, protection is on whatever the software flag is, and erase and program of the protection register are refused.
- R8: `stat_prot` is 1 while software protection is on or `wp_n` is low, and 0 otherwise.
- R9: A frame that starts with 32h, followed by three dummy bytes, returns one protection-register byte per later input byte, sector 0 first. Each byte appears on `rd_byte` with `rd_vld` high in the cycle after the input byte. Bytes past the last sector read 00h.
- R10: The bytes 3Dh 2Ah 7Fh 30h, followed by a sector index byte below the sector count, lock that sector at the end of the frame, and the lock can never be cleared. A frame starting with 35h, followed by three dummy bytes, reads the lockdown state as FFh for a locked sector and 00h for an unlocked one.
- R11: `sec_inhibit[i]` is 1 when sector i is locked, or when protection is on and the protection byte of sector i is nonzero.
- R12: At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Frame active (chip select asserted) |
| byte_vld | input | 1 | One-cycle strobe: a received byte is on `byte_in` |
| byte_in | input | 8 | Received byte, first byte of the frame first |
| wp_n | input | 1 | Write-protect pin; low forces protection |
| sec_inhibit | output | NSEC | Per-sector write inhibit |
| stat_prot | output | 1 | Protection bit of the status register |
| chip_erase_stb | output | 1 | Chip erase start pulse |
| preg_erase_stb | output | 1 | Protection-register erase pulse |
| preg_prog_stb | output | 1 | Protection-register program pulse |
| page_bin_stb | output | 1 | Binary page-size select pulse |
| rd_vld | output | 1 | Read byte valid |
| rd_byte | output | 8 | Read data byte |

## Verification
The bench builds the block with the default NSEC = 4. With four sectors, one read frame of five data bytes covers every sector and also the first index past the end. The same frame size lets lockdown be tried on the top sector and with an index that is out of range. Four sectors are also enough for a mixed pattern of zero and nonzero protection bytes, so the inhibit vector shows both the software path and the pin path. Expected read bytes pass through a scoreboard queue. Strobe counts are compared with totals that the bench keeps on its own side.

// File: rtl/sprot_cmd_ctrl.sv
module sprot_cmd_ctrl #(
  parameter int NSEC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            byte_vld,
  input  logic [7:0]      byte_in,
  input  logic            wp_n,
  output logic [NSEC-1:0] sec_inhibit,
  output logic            stat_prot,
  output logic            chip_erase_stb,
  output logic            preg_erase_stb,
  output logic            preg_prog_stb,
  output logic            page_bin_stb,
  output logic            rd_vld,
  output logic [7:0]      rd_byte
);
  localparam int IW = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam logic [7:0] NS8 = 8'(NSEC);

  typedef enum logic [3:0] {
    C_NONE, C_CHIP, C_PAGE, C_PERASE, C_PPROG, C_EN, C_DIS, C_LOCK, C_RDP, C_RDL
  } cmd_t;

  logic                 sel_q, armed, sw_en, lk_ok;
  logic [7:0]           cnt, b0, b1, b2, lk_idx;
  cmd_t                 cmd, dec4;
  logic [NSEC-1:0][7:0] preg, stage;
  logic [NSEC-1:0]      locked;

  wire        frame_end = sel_q & ~sel;
  wire        take      = sel & byte_vld;
  wire [7:0]  didx      = cnt - 8'd4;
  wire [IW-1:0] sidx    = didx[IW-1:0];

  always_comb begin
    case ({b0, b1, b2, byte_in})
      32'hC794_809A: dec4 = C_CHIP;
      32'h3D2A_80A6: dec4 = C_PAGE;
      32'h3D2A_7FCF: dec4 = C_PERASE;
      32'h3D2A_7FFC: dec4 = C_PPROG;
      32'h3D2A_7FA9: dec4 = C_EN;
      32'h3D2A_7F9A: dec4 = C_DIS;
      32'h3D2A_7F30: dec4 = C_LOCK;
      default:       dec4 = C_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0; cnt <= '0; cmd <= C_NONE; stage <= '0;
      b0 <= '0; b1 <= '0; b2 <= '0; lk_ok <= 1'b0; lk_idx <= '0;
    end else begin
      sel_q <= sel;
      if (!sel) begin
        cnt <= '0; cmd <= C_NONE; stage <= '0; lk_ok <= 1'b0;
      end else if (byte_vld) begin
        if (cnt != 8'hFF) cnt <= cnt + 8'd1;
        case (cnt)
          8'd0: b0 <= byte_in;
          8'd1: b1 <= byte_in;
          8'd2: b2 <= byte_in;
          default: ;
        endcase
        if (cnt == 8'd0)
          cmd <= (byte_in == 8'h32) ? C_RDP : (byte_in == 8'h35) ? C_RDL : C_NONE;
        else if (cnt == 8'd3 && cmd == C_NONE)
          cmd <= dec4;
        if (cmd == C_PPROG && cnt >= 8'd4 && didx < NS8)
          stage[sidx] <= byte_in;
        if (cmd == C_LOCK && cnt == 8'd4) begin
          lk_ok  <= byte_in < NS8;
          lk_idx <= byte_in;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preg <= '0; locked <= '0; armed <= 1'b0; sw_en <= 1'b0;
      chip_erase_stb <= 1'b0; preg_erase_stb <= 1'b0;
      preg_prog_stb <= 1'b0; page_bin_stb <= 1'b0;
    end else begin
      chip_erase_stb <= 1'b0; preg_erase_stb <= 1'b0;
      preg_prog_stb <= 1'b0; page_bin_stb <= 1'b0;
      if (frame_end) begin
        case (cmd)
          C_CHIP: chip_erase_stb <= 1'b1;
          C_PAGE: page_bin_stb <= 1'b1;
          C_PERASE: if (wp_n) begin
            preg <= '1; armed <= 1'b1; preg_erase_stb <= 1'b1;
          end
          C_PPROG: if (wp_n && armed) begin
            preg <= stage; armed <= 1'b0; preg_prog_stb <= 1'b1;
          end
          C_EN:  sw_en <= 1'b1;
          C_DIS: sw_en <= 1'b0;
          C_LOCK: if (lk_ok) locked[lk_idx[IW-1:0]] <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld <= 1'b0; rd_byte <= '0;
    end else begin
      rd_vld <= 1'b0;
      if (take && cnt >= 8'd4 && (cmd == C_RDP || cmd == C_RDL)) begin
        rd_vld <= 1'b1;
        if (didx >= NS8)      rd_byte <= 8'h00;
        else if (cmd == C_RDP) rd_byte <= preg[sidx];
        else                   rd_byte <= {8{locked[sidx]}};
      end
    end
  end

  assign stat_prot = sw_en | ~wp_n;

  for (genvar i = 0; i < NSEC; i++) begin : g_inh
    assign sec_inhibit[i] = locked[i] | (stat_prot & (|preg[i]));
  end

  a_r1_chip_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_stb |-> $past(sel_q) && !$past(sel));
  a_r5_prog_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    preg_prog_stb |-> $past(armed) && !armed);
  a_r7_wp_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> $stable(preg));
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (locked & $past(locked)) == $past(locked));
  a_r11_lock_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    &(~locked | sec_inhibit));
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chip_erase_stb, preg_erase_stb, preg_prog_stb, page_bin_stb}));
endmodule

// File: tb/sprot_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module sprot_cmd_ctrl_tb_top;
  localparam int NSEC = 4;
  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, byte_vld = 1'b0, wp_n = 1'b1;
  logic [7:0] byte_in = 8'h00;
  logic [NSEC-1:0] sec_inhibit;
  logic stat_prot, chip_erase_stb, preg_erase_stb, preg_prog_stb, page_bin_stb, rd_vld;
  logic [7:0] rd_byte;

  sprot_cmd_ctrl #(.NSEC(NSEC)) dut_i (.*);

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int t_chip = 0, t_pe = 0, t_pp = 0, t_pg = 0;
  int e_chip = 0, e_pe = 0, e_pp = 0, e_pg = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always @(posedge clk) begin
    if (chip_erase_stb) t_chip++;
    if (preg_erase_stb) t_pe++;
    if (preg_prog_stb)  t_pp++;
    if (page_bin_stb)   t_pg++;
  end

  always @(negedge clk) if (rst_n && rd_vld) begin
    n_run++;
    if (exp_q.size() == 0) begin
      n_fail++; $display("FAIL R9 unexpected read byte act=%h exp=none", rd_byte);
    end else begin
      logic [7:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      if (rd_byte !== e) begin
        n_fail++; $display("FAIL %s read act=%h exp=%h", t, rd_byte, e);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b[$]);
    @(negedge clk) sel = 1'b1;
    foreach (b[i]) begin
      @(negedge clk); byte_vld = 1'b1; byte_in = b[i];
      @(negedge clk); byte_vld = 1'b0;
    end
    @(negedge clk) sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobes(input string tag);
    chk({tag, " chip_erase count"}, t_chip, e_chip);
    chk({tag, " preg_erase count"}, t_pe, e_pe);
    chk({tag, " preg_prog count"}, t_pp, e_pp);
    chk({tag, " page count"}, t_pg, e_pg);
  endtask

  task automatic rd(input string tag, input logic [7:0] op, input logic [7:0] e[$]);
    logic [7:0] f[$];
    f = '{op, 8'h00, 8'h00, 8'h00};
    foreach (e[i]) begin exp_q.push_back(e[i]); tag_q.push_back(tag); f.push_back(8'hEE); end
    send(f);
    chk({tag, " all bytes returned"}, exp_q.size(), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++; $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R8 reset stat_prot", stat_prot, 0);
    chk("R11 reset inhibit", sec_inhibit, 0);
    strobes("R12 reset");

    send('{8'h3D, 8'h2A, 8'h80, 8'hA6}); e_pg++; strobes("R2 page size");
    send('{8'hC7, 8'h94, 8'h80, 8'h9A, 8'h12, 8'h34}); e_chip++; strobes("R1 chip erase trailing");
    send('{8'hC7, 8'h94, 8'h80}); strobes("R3 short frame");
    send('{8'h3D, 8'h2A, 8'h7F, 8'hFD}); strobes("R3 mismatch");
    send('{8'hC8, 8'h94, 8'h80, 8'h9A}); strobes("R3 first byte mismatch");

    send('{8'h3D, 8'h2A, 8'h7F, 8'hFC, 8'h55, 8'h55, 8'h55, 8'h55}); strobes("R5 unarmed program");
    rd("R5 unarmed keeps 00", 8'h32, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00});

    send('{8'h3D, 8'h2A, 8'h7F, 8'hA9});
    chk("R6 enable stat_prot", stat_prot, 1);
    chk("R11 enabled zero bytes", sec_inhibit, 4'b0000);

    send('{8'h3D, 8'h2A, 8'h7F, 8'hCF}); e_pe++; strobes("R4 erase");
    rd("R4 erased FF", 8'h32, '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00});
    chk("R11 erased inhibit", sec_inhibit, 4'b1111);

    send('{8'h3D, 8'h2A, 8'h7F, 8'hFC, 8'h11, 8'h00, 8'h22}); e_pp++; strobes("R5 program");
    rd("R5 programmed", 8'h32, '{8'h11, 8'h00, 8'h22, 8'h00, 8'h00});
    chk("R11 mixed inhibit", sec_inhibit, 4'b0101);

    send('{8'h3D, 8'h2A, 8'h7F, 8'hFC, 8'h77, 8'h77, 8'h77, 8'h77}); strobes("R5 arm consumed");
    rd("R5 unchanged", 8'h32, '{8'h11, 8'h00, 8'h22, 8'h00});

    send('{8'h3D, 8'h2A, 8'h7F, 8'h9A}); strobes("R6 disable no strobe");
    chk("R6 disable stat_prot", stat_prot, 0);
    chk("R11 disabled inhibit", sec_inhibit, 4'b0000);

    @(negedge clk) wp_n = 1'b0; @(negedge clk);
    chk("R8 wp stat_prot", stat_prot, 1);
    chk("R7 wp inhibit", sec_inhibit, 4'b0101);
    send('{8'h3D, 8'h2A, 8'h7F, 8'hCF}); strobes("R7 erase refused");
    rd("R7 read under wp", 8'h32, '{8'h11, 8'h00, 8'h22, 8'h00});
    send('{8'h3D, 8'h2A, 8'h7F, 8'h9A});
    chk("R7 disable ignored under wp", stat_prot, 1);
    @(negedge clk) wp_n = 1'b1; @(negedge clk);
    chk("R8 wp released", stat_prot, 0);

    send('{8'h3D, 8'h2A, 8'h7F, 8'h30, 8'h03});
    chk("R10 lock sector 3", sec_inhibit, 4'b1000);
    send('{8'h3D, 8'h2A, 8'h7F, 8'h30, 8'h07});
    chk("R10 out-of-range index", sec_inhibit, 4'b1000);
    rd("R10 lockdown read", 8'h35, '{8'h00, 8'h00, 8'h00, 8'hFF, 8'h00});

    send('{8'h3D, 8'h2A, 8'h7F, 8'hCF}); e_pe++;
    send('{8'h3D, 8'h2A, 8'h7F, 8'hFC}); e_pp++; strobes("R5 empty program");
    rd("R5 missing bytes 00", 8'h32, '{8'h00, 8'h00, 8'h00, 8'h00});
    send('{8'h3D, 8'h2A, 8'h7F, 8'hA9});
    chk("R10 lock survives", sec_inhibit, 4'b1000);
    strobes("R12 final");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule